// File: doc/BRIEF.md
# Parity-Protected Control Store Programming Port

This block lets a host fill a 40-bit instruction control store through three registers on a small read/write port. The host first writes an index register whose top bit switches programming on and whose low bits hold the starting location. It then sends each instruction as two writes. The first write carries the low 32 bits, and the block only holds them. The second write carries the top byte. That write commits the full instruction to the store and steps the index forward.

Every stored word is 42 bits wide. The block computes two even-parity bits, one over each 20-bit half of the instruction, and places them above the instruction bits. After the host writes the last location, the index returns to zero. The host can see this because the index register then reads back as programming-on with an index of zero. To end programming, the host writes zero to the index register. While programming is off, the store is never written.

Top module: `ucode_store_loader`

## Requirements
- R1: After reset, programming is off, the index is 0, a read of offset 0x000 returns 0x00000000, and the store write strobe is low.
- R2: A write to offset 0x000 sets the programming flag from data bit 31 and the index from the low index bits. A read of 0x000 returns the flag in bit 31 and the index in the low bits, with zeros elsewhere. Read data appears the cycle after the read strobe.
- R3: A write to offset 0x004 holds the 32-bit value as instruction bits [31:0] and produces no store write.
- R4: While programming is on, a write to offset 0x008 raises the store write strobe for exactly one cycle, starting the next cycle. The write goes to the current index. Data bits [7:0] of the write become instruction bits [39:32], and the held low word becomes bits [31:0].
- R5: Stored bit 40 is the XOR of instruction bits [19:0]. Stored bit 41 is the XOR of instruction bits [39:20].
- R6: Bits [31:8] of a write to offset 0x008 have no effect on the stored word.
- R7: Each commit advances the index by one.
- R8: A commit at the last location (DEPTH-1) returns the index to 0, so a read of 0x000 then returns 0x80000000.
- R9: While programming is off, a write to offset 0x008 causes no store write and leaves the index unchanged.
- R10: Writing 0x00000000 to offset 0x000 ends programming. The flag reads back as 0 and later commits are blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| cs_we | output | 1 | Control store write enable |
| cs_addr | output | AW | Control store write address |
| cs_wdata | output | 42 | Control store word: parity in [41:40], instruction in [39:0] |

## Verification
A wrong index appears at the ports on the next commit, because cs_addr goes off the expected sequence. It also shows on any read of offset 0x000 one cycle later. A stale or wrongly merged low word, or a parity error, shows in cs_wdata in the cycle after the upper-word write. A wrong programming flag shows as a missing or unexpected cs_we pulse in that same cycle. The wrap case is checked by committing at the last location, which keeps the failure window to a single commit.

// File: rtl/uls_pkg.sv
package uls_pkg;
  localparam int OFF_W = 12;
  localparam logic [OFF_W-1:0] OFF_INDEX = 12'h000;
  localparam logic [OFF_W-1:0] OFF_LOWER = 12'h004;
  localparam logic [OFF_W-1:0] OFF_UPPER = 12'h008;
  localparam int INSN_W = 40;
  localparam int WORD_W = 42;

  function automatic logic even_par20(input logic [19:0] v);
    return ^v;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic [31:0] lo,
                                                  input logic [7:0] hi);
    logic [INSN_W-1:0] insn;
    insn = {hi, lo};
    return {even_par20(insn[39:20]), even_par20(insn[19:0]), insn};
  endfunction
endpackage

// File: rtl/uls_index.sv
module uls_index #(
  parameter int DEPTH = 4096,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_prog,
  input  logic [AW-1:0] load_idx,
  input  logic          step,
  output logic [AW-1:0] idx,
  output logic          prog,
  output logic          wrap_evt
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] idx_next;

  assign wrap_evt = step && (idx == LAST);
  assign idx_next = wrap_evt ? '0 : idx + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      prog <= 1'b0;
    end else if (load) begin
      idx  <= load_idx;
      prog <= load_prog;
    end else if (step) begin
      idx <= idx_next;
    end
  end
endmodule

// File: rtl/uls_commit.sv
module uls_commit
  import uls_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [AW-1:0]     idx,
  input  logic [31:0]       lower,
  input  logic [7:0]        upper,
  output logic              we,
  output logic [AW-1:0]     addr,
  output logic [WORD_W-1:0] wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else begin
      we <= commit;
      if (commit) begin
        addr  <= idx;
        wdata <= pack_word(lower, upper);
      end
    end
  end
endmodule

// File: rtl/ucode_store_loader.sv
module ucode_store_loader
  import uls_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cs_we,
  output logic [AW-1:0]     cs_addr,
  output logic [WORD_W-1:0] cs_wdata
);
  logic          wr_index, wr_lower, wr_upper;
  logic          commit_evt, wrap_evt, prog_q;
  logic [AW-1:0] idx_q;
  logic [31:0]   lower_q;
  logic [31:0]   index_view;

  assign wr_index   = reg_wr && (reg_off == OFF_INDEX);
  assign wr_lower   = reg_wr && (reg_off == OFF_LOWER);
  assign wr_upper   = reg_wr && (reg_off == OFF_UPPER);
  assign commit_evt = wr_upper && prog_q;

  uls_index #(.DEPTH(DEPTH), .AW(AW)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_index),
    .load_prog(reg_wdata[31]),
    .load_idx (reg_wdata[AW-1:0]),
    .step     (commit_evt),
    .idx      (idx_q),
    .prog     (prog_q),
    .wrap_evt (wrap_evt)
  );

  uls_commit #(.AW(AW)) u_commit (
    .clk   (clk),
    .rst_n (rst_n),
    .commit(commit_evt),
    .idx   (idx_q),
    .lower (lower_q),
    .upper (reg_wdata[7:0]),
    .we    (cs_we),
    .addr  (cs_addr),
    .wdata (cs_wdata)
  );

  always_comb begin
    index_view = '0;
    index_view[AW-1:0] = idx_q;
    index_view[31] = prog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lower_q   <= '0;
      reg_rdata <= '0;
    end else begin
      if (wr_lower) lower_q <= reg_wdata;
      if (reg_rd) reg_rdata <= (reg_off == OFF_INDEX) ? index_view : 32'h0;
    end
  end
endmodule

// File: rtl/uls_checker.sv
module uls_checker #(
  parameter int DEPTH = 4096,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          commit_evt,
  input logic          wrap_evt,
  input logic          prog_q,
  input logic          wr_index,
  input logic [AW-1:0] idx_q,
  input logic          cs_we,
  input logic [AW-1:0] cs_addr,
  input logic [41:0]   cs_wdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R4
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> cs_we);
  // R9
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> !cs_we);
  // R4
  commit_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> cs_addr == $past(idx_q));
  // R7
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && !wr_index && idx_q != LAST) |=> idx_q == $past(idx_q) + AW'(1));
  // R8
  index_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !wr_index) |=> idx_q == '0 && prog_q);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_q && !wr_index) |=> $stable(idx_q));
  // R5
  parity_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_we |-> cs_wdata[40] == ^cs_wdata[19:0]);
  // R5
  parity_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_we |-> cs_wdata[41] == ^cs_wdata[39:20]);
endmodule

bind ucode_store_loader uls_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .commit_evt(commit_evt),
  .wrap_evt  (wrap_evt),
  .prog_q    (prog_q),
  .wr_index  (wr_index),
  .idx_q     (idx_q),
  .cs_we     (cs_we),
  .cs_addr   (cs_addr),
  .cs_wdata  (cs_wdata)
);

// File: tb/ucode_store_loader_test.sv
module ucode_store_loader_test;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_off = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cs_we;
  logic [AW-1:0] cs_addr;
  logic [41:0] cs_wdata;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [AW+41:0] exp_q[$];
  logic [31:0] held_lo = '0;
  logic [AW-1:0] model_idx = '0;
  bit model_prog = 0;

  always #10 clk = ~clk;

  ucode_store_loader #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cs_we(cs_we), .cs_addr(cs_addr), .cs_wdata(cs_wdata));

  function automatic logic [41:0] expect_word(input logic [39:0] insn);
    logic p_lo = 1'b0, p_hi = 1'b0;
    for (int b = 0; b < 20; b++) p_lo = p_lo ^ insn[b];
    for (int b = 20; b < 40; b++) p_hi = p_hi ^ insn[b];
    return {p_hi, p_lo, insn};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_wdata = d;
    if (off == 12'h000) begin
      model_prog = d[31]; model_idx = d[AW-1:0];
    end else if (off == 12'h004) begin
      held_lo = d;
    end else if (off == 12'h008 && model_prog) begin
      exp_q.push_back({model_idx, expect_word({d[7:0], held_lo})});
      model_idx = model_idx + 1'b1;
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_index(input string req);
    logic [31:0] e;
    @(negedge clk);
    reg_rd = 1'b1; reg_off = 12'h000;
    @(negedge clk);
    reg_rd = 1'b0;
    e = '0; e[AW-1:0] = model_idx; e[31] = model_prog;
    check(reg_rdata == e, req, reg_rdata, e);
  endtask

  task automatic put_insn(input logic [39:0] insn, input logic [23:0] junk);
    reg_write(12'h004, insn[31:0]);
    check(cs_we == 1'b0, "R3 lower write no store", cs_we, 0);
    reg_write(12'h008, {junk, insn[39:32]});
  endtask

  // scoreboard monitor: R4 R5 R6
  always @(negedge clk) begin
    if (rst_n && cs_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected store write", cs_addr, 0);
      end else begin
        logic [AW+41:0] e;
        e = exp_q.pop_front();
        check({cs_addr, cs_wdata} == e, "R4/R5/R6 store word", {cs_addr, cs_wdata}, e);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_we == 1'b0, "R1 reset strobe", cs_we, 0);
    rst_n = 1'b1;
    read_index("R1 reset index");

    reg_write(12'h000, 32'h80000000);
    read_index("R2 start at zero");
    put_insn(40'hF0000C0300, 24'h0);
    put_insn(40'hFFFFFFFFFF, 24'hABCDEF);
    put_insn(40'h0000080000, 24'h0);
    put_insn(40'h0000100000, 24'h123456);
    read_index("R7 index after four commits");

    reg_write(12'h000, 32'h80000009);
    read_index("R2 arbitrary index");
    put_insn(40'h123456789A, 24'hFFFFFF);
    read_index("R7 index step");

    reg_write(12'h000, 32'h80000000 | (DEPTH - 1));
    put_insn(40'h5A5A5A5A5A, 24'h0);
    read_index("R8 wrap readback 0x80000000");
    check(model_idx == 0, "R8 model wrapped", model_idx, 0);

    reg_write(12'h000, 32'h00000000);
    read_index("R10 programming ended");
    put_insn(40'h1111111111, 24'h0);
    check(cs_we == 1'b0, "R9 upper ignored when off", cs_we, 0);
    read_index("R9 index unchanged");

    reg_write(12'h000, 32'h00000003);
    put_insn(40'h2222222222, 24'h0);
    check(cs_we == 1'b0, "R9 no write at index 3", cs_we, 0);
    read_index("R9 index stays 3");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 all commits seen", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule